// File: doc/BRIEF.md
# Maskable Write-One-to-Clear Interrupt Controller

This block gathers six management event sources into one shared interrupt line. Each event arrives as a single-cycle pulse and sets a sticky bit in a status register. The mask register decides whether that bit can pull the line. Software reads the status register to find out which events fired. It then acknowledges them by writing ones to those bits.

The interrupt output is active low. A configuration bit can switch the output driver off. This is modelled as an output-enable that a pad ring turns into a high-impedance pin.

All three registers are written through a simple strobe, a register select and a data byte. Their contents are presented continuously on output ports for the host bus to read. The block has no bus protocol of its own.

Top module: `irq_w1c_ctrl`

## Requirements
- R1: After a synchronous reset, the following hold: status reads 0, the mask reads all ones (every event masked), the configuration reads 0, `irq_n` is 1 and `irq_oe` is 1.
- R2: An event pulse on `evt_i[k]` sets status bit k at the same clock edge, whatever the mask holds. Bit order is 0 source address mismatch, 1 management bus error, 2 memory write done, 3 memory read done, 4 invalid port number, 5 attribute counter overflow.
- R3: A write with `wr_addr`=0 clears every status bit whose `wr_data` bit is 1. Status bits whose `wr_data` bit is 0 keep their value.
- R4: If an event pulse and a clearing write hit the same status bit in one cycle, the bit ends up set.
- R5: After each clock edge, `irq_n` is 0 exactly when some status bit is 1 while its mask bit is 0. It reflects register changes made at that same edge.
- R6: A write with `wr_addr`=1 loads the low six data bits into the mask, where 1 means masked. A mask write leaves the status register unchanged.
- R7: A write with `wr_addr`=2 loads the configuration byte. When configuration bit 6 is 1, `irq_oe` is 0; otherwise it is 1. `irq_n` keeps its value regardless of this bit.
- R8: A write with `wr_addr`=3 changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 6 | Event pulses, one per source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 status, 1 mask, 2 configuration, 3 none |
| wr_data | input | 8 | Write data |
| stat_o | output | 6 | Status register |
| mask_o | output | 6 | Mask register |
| cfg_o | output | 8 | Configuration register |
| irq_n | output | 1 | Shared interrupt, active low, registered |
| irq_oe | output | 1 | Output enable for the interrupt driver |

## Verification
The bench sweeps every mask value against every status pattern. A wrong polarity in the mask gate, or an output taken from the wrong pipeline stage, would show up as `irq_n` disagreeing with the register contents. It also crosses every event pattern with every clearing pattern in the same cycle. A design that let the clear win would lose events. A design that treated written zeros as clears would drop bits that nobody acknowledged. Writes to the configuration register and to the unmapped address confirm two things: only bit 6 switches the driver off, and nothing else disturbs the interrupt state.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_MASK = 2'd1,
    SEL_CFG  = 2'd2,
    SEL_NONE = 2'd3
  } irqc_sel_e;
endpackage

// File: rtl/irqc_status.sv
module irqc_status #(
  parameter int NUM_SRC = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               clr_en_i,
  input  logic [NUM_SRC-1:0] clr_bits_i,
  output logic [NUM_SRC-1:0] stat_d_o,
  output logic [NUM_SRC-1:0] stat_q_o
);
  logic [NUM_SRC-1:0] stat_q;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_bit
    always_comb begin
      if (evt_i[k])
        stat_d_o[k] = 1'b1;
      else if (clr_en_i && clr_bits_i[k])
        stat_d_o[k] = 1'b0;
      else
        stat_d_o[k] = stat_q[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= stat_d_o;
  end

  assign stat_q_o = stat_q;

  // R2
  evt_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_i != '0) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));
  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_en_i |=> ((stat_q & $past(clr_bits_i & ~evt_i)) == '0));
  // R3
  zero_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_i == '0 && !clr_en_i) |=> $stable(stat_q));
endmodule

// File: rtl/irqc_ctrl_regs.sv
module irqc_ctrl_regs #(
  parameter int NUM_SRC = 6,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mask_we_i,
  input  logic               cfg_we_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic [NUM_SRC-1:0] mask_d_o,
  output logic [NUM_SRC-1:0] mask_q_o,
  output logic [DATA_W-1:0]  cfg_d_o,
  output logic [DATA_W-1:0]  cfg_q_o
);
  logic [NUM_SRC-1:0] mask_q;
  logic [DATA_W-1:0]  cfg_q;

  always_comb begin
    mask_d_o = mask_we_i ? data_i[NUM_SRC-1:0] : mask_q;
    cfg_d_o  = cfg_we_i  ? data_i : cfg_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      cfg_q  <= '0;
    end else begin
      mask_q <= mask_d_o;
      cfg_q  <= cfg_d_o;
    end
  end

  assign mask_q_o = mask_q;
  assign cfg_q_o  = cfg_q;

  // R8
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!mask_we_i && !cfg_we_i) |=> ($stable(mask_q) && $stable(cfg_q)));
endmodule

// File: rtl/irqc_out.sv
module irqc_out #(
  parameter int NUM_SRC = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] stat_d_i,
  input  logic [NUM_SRC-1:0] mask_d_i,
  input  logic               drv_off_d_i,
  output logic               irq_n_o,
  output logic               oe_o
);
  logic pending;

  assign pending = |(stat_d_i & ~mask_d_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_n_o <= 1'b1;
      oe_o    <= 1'b1;
    end else begin
      irq_n_o <= ~pending;
      oe_o    <= ~drv_off_d_i;
    end
  end
endmodule

// File: rtl/irq_w1c_ctrl.sv
module irq_w1c_ctrl #(
  parameter int NUM_SRC   = 6,
  parameter int DATA_W    = 8,
  parameter int OFF_BIT   = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [NUM_SRC-1:0] stat_o,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [DATA_W-1:0]  cfg_o,
  output logic               irq_n,
  output logic               irq_oe
);
  import irqc_pkg::*;

  irqc_sel_e          sel;
  logic               stat_we, mask_we, cfg_we;
  logic [NUM_SRC-1:0] stat_d, mask_d;
  logic [DATA_W-1:0]  cfg_d;

  assign sel     = irqc_sel_e'(wr_addr);
  assign stat_we = wr_en && (sel == SEL_STAT);
  assign mask_we = wr_en && (sel == SEL_MASK);
  assign cfg_we  = wr_en && (sel == SEL_CFG);

  irqc_status #(.NUM_SRC(NUM_SRC)) u_status (
    .clk        (clk),
    .rst        (rst),
    .evt_i      (evt_i),
    .clr_en_i   (stat_we),
    .clr_bits_i (wr_data[NUM_SRC-1:0]),
    .stat_d_o   (stat_d),
    .stat_q_o   (stat_o)
  );

  irqc_ctrl_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .mask_we_i (mask_we),
    .cfg_we_i  (cfg_we),
    .data_i    (wr_data),
    .mask_d_o  (mask_d),
    .mask_q_o  (mask_o),
    .cfg_d_o   (cfg_d),
    .cfg_q_o   (cfg_o)
  );

  irqc_out #(.NUM_SRC(NUM_SRC)) u_out (
    .clk         (clk),
    .rst         (rst),
    .stat_d_i    (stat_d),
    .mask_d_i    (mask_d),
    .drv_off_d_i (cfg_d[OFF_BIT]),
    .irq_n_o     (irq_n),
    .oe_o        (irq_oe)
  );

  // R5
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_n == ~|(stat_o & ~mask_o)));
  // R7
  drv_off_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_oe == ~cfg_o[OFF_BIT]));
  // R4
  evt_beats_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_we && (evt_i & wr_data[NUM_SRC-1:0]) != '0)
      |=> ((stat_o & $past(evt_i)) == $past(evt_i)));
  // R6
  mask_no_stat_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_we && evt_i == '0) |=> $stable(stat_o));
endmodule

// File: tb/irq_w1c_ctrl_bench.sv
module irq_w1c_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] evt_i = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [5:0] stat_o, mask_o;
  logic [7:0] cfg_o;
  logic       irq_n, irq_oe;

  int n_cmp = 0;
  int n_bad = 0;
  logic [5:0] m_stat = '0;
  logic [5:0] m_mask = '1;
  logic [7:0] m_cfg  = '0;
  logic       m_irq_n = 1'b1;
  logic       m_oe = 1'b1;

  always #2 clk = ~clk;

  irq_w1c_ctrl u_irq_w1c_ctrl (
    .clk(clk), .rst(rst), .evt_i(evt_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .stat_o(stat_o), .mask_o(mask_o), .cfg_o(cfg_o),
    .irq_n(irq_n), .irq_oe(irq_oe)
  );

  task automatic cmp(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    cmp(req, "stat", int'(stat_o), int'(m_stat));
    cmp(req, "mask", int'(mask_o), int'(m_mask));
    cmp(req, "cfg", int'(cfg_o), int'(m_cfg));
    cmp(req, "irq_n", int'(irq_n), int'(m_irq_n));
    cmp(req, "irq_oe", int'(irq_oe), int'(m_oe));
  endtask

  // One clock: drive, take the edge, update the model, then compare
  task automatic step(input logic [5:0] ev, input logic we, input logic [1:0] a,
                      input logic [7:0] d, input string req);
    evt_i = ev; wr_en = we; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    if (we && a == 2'd0) m_stat = m_stat & ~d[5:0];
    m_stat = m_stat | ev;
    if (we && a == 2'd1) m_mask = d[5:0];
    if (we && a == 2'd2) m_cfg = d;
    m_irq_n = ((m_stat & ~m_mask) == 6'd0);
    m_oe = !m_cfg[6];
    evt_i = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    check_all(req);
  endtask

  initial begin
    for (int w = 0; w < 200000; w++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    check_all("R1");

    // R2 events set status while fully masked
    step(6'h15, 1'b0, 2'd0, 8'h00, "R2");
    step(6'h2A, 1'b0, 2'd0, 8'h00, "R2");
    step(6'h00, 1'b1, 2'd0, 8'hFF, "R3");

    // R5 / R6 sweep of every mask against every status pattern
    for (int m = 0; m < 64; m++) begin
      step(6'h00, 1'b1, 2'd1, 8'(m), "R6");
      for (int s = 0; s < 64; s++) begin
        step(6'(s), 1'b0, 2'd0, 8'h00, "R5");
        step(6'h00, 1'b1, 2'd0, 8'h3F, "R3");
      end
    end

    // R3 / R4 every event pattern against every clear pattern
    step(6'h00, 1'b1, 2'd1, 8'h00, "R6");
    for (int c = 0; c < 64; c++) begin
      for (int s = 0; s < 64; s++) begin
        step(6'h3F, 1'b0, 2'd0, 8'h00, "R2");
        step(6'(s), 1'b1, 2'd0, 8'(c), "R4");
      end
    end
    // R3 writing zeros clears nothing
    step(6'h3F, 1'b0, 2'd0, 8'h00, "R2");
    step(6'h00, 1'b1, 2'd0, 8'hC0, "R3");

    // R7 driver enable under configuration bit 6
    step(6'h00, 1'b1, 2'd2, 8'h40, "R7");
    step(6'h00, 1'b1, 2'd2, 8'hBF, "R7");
    step(6'h00, 1'b1, 2'd2, 8'hFF, "R7");
    step(6'h00, 1'b1, 2'd0, 8'h3F, "R7");
    step(6'h04, 1'b0, 2'd0, 8'h00, "R7");

    // R8 unmapped address has no effect
    step(6'h00, 1'b1, 2'd3, 8'hFF, "R8");
    step(6'h00, 1'b1, 2'd3, 8'h00, "R8");
    step(6'h00, 1'b1, 2'd1, 8'h3F, "R6");
    step(6'h00, 1'b1, 2'd3, 8'h00, "R8");

    // R1 reset again from a busy state
    step(6'h3F, 1'b0, 2'd0, 8'h00, "R2");
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    m_stat = '0; m_mask = '1; m_cfg = '0; m_irq_n = 1'b1; m_oe = 1'b1;
    check_all("R1");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule